// File: doc/BRIEF.md
# Predicated Vector Writeback and Store Stage

This block is the final stage of a sixteen-lane vector datapath. Each request carries a result vector of sixteen 32-bit slots, a 16-bit predicate, an element-size flag and a destination select. The destination is either an entry of a small vector register file inside the block or one line of memory reached through a byte-enabled write port. Only the slots chosen by the predicate are written. Every other slot keeps whatever it held before, in the register file and in memory alike. Integer and single-precision results use the narrow mode, in which there is one predicate bit per 32-bit slot. Double-precision results use the wide mode, in which one predicate bit covers a 64-bit element made of two adjacent slots.

A request is accepted when `req_valid` and `req_ready` are both high at a rising clock edge. A register write completes at that edge. A store moves a two-state machine from `ST_IDLE` to `ST_STORE`; this transition is called *launch*. The machine stays in `ST_STORE` (*stall*) until the memory side raises `mem_ready`. It then returns to `ST_IDLE` (*retire*). While a request is accepted in `ST_IDLE` without launching a store, the machine takes the *idle-hold* transition. The register file has one read port with a latency of one cycle.

Top module: `vwb_top`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_valid` is 0 and every register file entry reads as zero.
- R2: In narrow mode (`req_wide`=0), a register write updates slot s, which is bits [32s+31:32s], exactly when predicate bit s is 1.
- R3: Slots whose predicate selects them not are left unchanged by a register write.
- R4: In wide mode (`req_wide`=1), predicate bit k (k = 0..7) selects slots 2k and 2k+1. Predicate bits 8 to 15 have no effect.
- R5: A store presents the request data unchanged on `mem_data`. `mem_be` bits 4s to 4s+3 are all 1 when slot s is selected and all 0 otherwise.
- R6: `mem_valid` rises in the cycle after a store is accepted. Address, data and byte enables stay stable until a cycle in which `mem_ready` is 1. `req_ready` is 0 while `mem_valid` is 1.
- R7: A request that selects no slot is still accepted. It changes no register and raises no `mem_valid`.
- R8: `rd_data` shows the entry named by `rd_idx` one cycle later. A read in the same cycle as a write to that entry returns the value from before the write.
- R9: `req_to_mem`=1 routes a request to memory and leaves the register file untouched. `req_to_mem`=0 writes the register named by `req_reg` and never raises `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_to_mem | input | 1 | 1 selects memory as destination, 0 selects the register file |
| req_wide | input | 1 | 1 selects 64-bit elements |
| req_reg | input | 3 | Destination register index |
| req_addr | input | 32 | Destination line address |
| req_mask | input | 16 | Predicate, one bit per lane |
| req_data | input | 512 | Result vector, slot s at bits [32s+31:32s] |
| rd_idx | input | 3 | Read port register index |
| rd_data | output | 512 | Read port data, one cycle after `rd_idx` |
| mem_valid | output | 1 | Store pending |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | 32 | Store line address |
| mem_data | output | 512 | Store data |
| mem_be | output | 64 | Store byte enables |

## Verification
The hardest case to produce is a read that meets a register write to the same entry at the same clock edge. It exposes whether old or new contents leave the read port. The bench drives the write request and the read index in the same half cycle, after waiting until no store is outstanding. A second difficult case is a wide-mode request whose predicate has only upper bits set. The bench sends it both to the register file and to memory and confirms that nothing changes. Stores meet a memory side that refuses two cycles out of three, so the *stall* transition and the hold-stable rule are both exercised.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_STORE = 1'b1
    } st_e;
endpackage

// File: rtl/vwb_mask_expand.sv
module vwb_mask_expand #(
    parameter int LANES  = 16,
    parameter int SLOT_W = 32
) (
    input  logic [LANES-1:0]              pred,
    input  logic                          wide,
    output logic [LANES-1:0]              slot_en,
    output logic [LANES*(SLOT_W/8)-1:0]   byte_en
);
    localparam int BPS = SLOT_W / 8;

    for (genvar s = 0; s < LANES; s++) begin : g_slot
        // wide mode: pair (2k, 2k+1) follows predicate bit k
        assign slot_en[s] = wide ? pred[s/2] : pred[s];
        for (genvar b = 0; b < BPS; b++) begin : g_byte
            assign byte_en[s*BPS + b] = slot_en[s];
        end
    end
endmodule

// File: rtl/vwb_regfile.sv
module vwb_regfile #(
    parameter int LANES  = 16,
    parameter int SLOT_W = 32,
    parameter int NREGS  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [$clog2(NREGS)-1:0]    wr_idx,
    input  logic [LANES-1:0]            slot_en,
    input  logic [LANES*SLOT_W-1:0]     wr_data,
    input  logic [$clog2(NREGS)-1:0]    rd_idx,
    output logic [LANES*SLOT_W-1:0]     rd_data
);
    localparam int VEC_W = LANES * SLOT_W;

    logic [VEC_W-1:0] rf [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) begin
                rf[r] <= '0;
            end
            rd_data <= '0;
        end else begin
            // registered read sees contents from before this edge's write
            rd_data <= rf[rd_idx];
            if (we) begin
                for (int s = 0; s < LANES; s++) begin
                    if (slot_en[s]) begin
                        rf[wr_idx][s*SLOT_W +: SLOT_W] <= wr_data[s*SLOT_W +: SLOT_W];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vwb_store_fsm.sv
module vwb_store_fsm
    import vwb_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int SLOT_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          launch,
    input  logic [ADDR_W-1:0]             in_addr,
    input  logic [LANES*SLOT_W-1:0]       in_data,
    input  logic [LANES*(SLOT_W/8)-1:0]   in_be,
    input  logic                          mem_ready,
    output logic                          busy,
    output logic                          mem_valid,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [LANES*SLOT_W-1:0]       mem_data,
    output logic [LANES*(SLOT_W/8)-1:0]   mem_be
);
    st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            mem_addr <= '0;
            mem_data <= '0;
            mem_be   <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && launch) begin
                mem_addr <= in_addr;
                mem_data <= in_data;
                mem_be   <= in_be;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (launch)    st_d = ST_STORE;  // launch, else idle-hold
            ST_STORE: if (mem_ready) st_d = ST_IDLE;   // retire, else stall
            default:                 st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        mem_valid = 1'b0;
        unique case (st_q)
            ST_IDLE:  begin busy = 1'b0; mem_valid = 1'b0; end
            ST_STORE: begin busy = 1'b1; mem_valid = 1'b1; end
            default:  begin busy = 1'b0; mem_valid = 1'b0; end
        endcase
    end
endmodule

// File: rtl/vwb_top.sv
module vwb_top #(
    parameter int LANES  = 16,
    parameter int SLOT_W = 32,
    parameter int NREGS  = 8,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_to_mem,
    input  logic                          req_wide,
    input  logic [$clog2(NREGS)-1:0]      req_reg,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [LANES-1:0]              req_mask,
    input  logic [LANES*SLOT_W-1:0]       req_data,
    input  logic [$clog2(NREGS)-1:0]      rd_idx,
    output logic [LANES*SLOT_W-1:0]       rd_data,
    output logic                          mem_valid,
    input  logic                          mem_ready,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [LANES*SLOT_W-1:0]       mem_data,
    output logic [LANES*(SLOT_W/8)-1:0]   mem_be
);
    localparam int BE_W = LANES * (SLOT_W / 8);

    logic [LANES-1:0] slot_en;
    logic [BE_W-1:0]  byte_en;
    logic             busy;
    logic             accept;
    logic             any_sel;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign any_sel   = |slot_en;

    vwb_mask_expand #(.LANES(LANES), .SLOT_W(SLOT_W)) u_expand (
        .pred    (req_mask),
        .wide    (req_wide),
        .slot_en (slot_en),
        .byte_en (byte_en)
    );

    vwb_regfile #(.LANES(LANES), .SLOT_W(SLOT_W), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (accept && !req_to_mem && any_sel),
        .wr_idx  (req_reg),
        .slot_en (slot_en),
        .wr_data (req_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    vwb_store_fsm #(.LANES(LANES), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (accept && req_to_mem && any_sel),
        .in_addr   (req_addr),
        .in_data   (req_data),
        .in_be     (byte_en),
        .mem_ready (mem_ready),
        .busy      (busy),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_be    (mem_be)
    );
endmodule

// File: rtl/vwb_checks.sv
module vwb_checks #(
    parameter int LANES  = 16,
    parameter int SLOT_W = 32,
    parameter int ADDR_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          req_to_mem,
    input logic                          req_wide,
    input logic [LANES-1:0]              req_mask,
    input logic                          mem_valid,
    input logic                          mem_ready,
    input logic [ADDR_W-1:0]             mem_addr,
    input logic [LANES*SLOT_W-1:0]       mem_data,
    input logic [LANES*(SLOT_W/8)-1:0]   mem_be
);
    localparam int BPS  = SLOT_W / 8;
    localparam int BE_W = LANES * BPS;
    localparam int HALF = LANES / 2;

    function automatic logic groups_whole(input logic [BE_W-1:0] be);
        for (int s = 0; s < LANES; s++) begin
            if (be[s*BPS +: BPS] != '0 && be[s*BPS +: BPS] != {BPS{1'b1}}) begin
                return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    logic acc;
    logic none_sel;
    assign acc      = req_valid && req_ready;
    assign none_sel = req_wide ? (req_mask[HALF-1:0] == '0) : (req_mask == '0);

    p_ready_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)));

    p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_to_mem && !none_sel) |=> mem_valid);

    p_empty_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && none_sel) |=> !mem_valid);

    p_reg_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_to_mem) |=> !mem_valid);

    p_be_whole_slots_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> groups_whole(mem_be));

    p_be_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_be != '0));
endmodule

bind vwb_top vwb_checks #(.LANES(LANES), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_to_mem (req_to_mem),
    .req_wide   (req_wide),
    .req_mask   (req_mask),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_be     (mem_be)
);

// File: tb/vwb_top_bench.sv
`timescale 1ns/1ps
module vwb_top_bench;
    localparam int LANES = 16;
    localparam int SW    = 32;
    localparam int VW    = LANES * SW;
    localparam int BW    = LANES * 4;

    typedef struct packed {
        logic [31:0]   addr;
        logic [VW-1:0] data;
        logic [BW-1:0] be;
    } st_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_to_mem = 1'b0;
    logic          req_wide = 1'b0;
    logic [2:0]    req_reg = '0;
    logic [31:0]   req_addr = '0;
    logic [15:0]   req_mask = '0;
    logic [VW-1:0] req_data = '0;
    logic [2:0]    rd_idx = '0;
    logic [VW-1:0] rd_data;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [31:0]   mem_addr;
    logic [VW-1:0] mem_data;
    logic [BW-1:0] mem_be;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int pushed = 0;
    int popped = 0;
    st_item_t      exp_q[$];
    logic [VW-1:0] model [8];
    st_item_t      prev;
    bit            have_prev = 1'b0;

    always #10 clk = ~clk;

    vwb_top u_vwb_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_to_mem(req_to_mem), .req_wide(req_wide), .req_reg(req_reg),
        .req_addr(req_addr), .req_mask(req_mask), .req_data(req_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be)
    );

    task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sel(input logic wide, input logic [15:0] m);
        logic [15:0] r;
        for (int s = 0; s < 16; s++) r[s] = wide ? m[s/2] : m[s];
        return r;
    endfunction

    function automatic logic [VW-1:0] pattern(input logic [15:0] seed);
        logic [VW-1:0] v;
        for (int s = 0; s < LANES; s++) v[s*SW +: SW] = {seed, 8'hA0 ^ 8'(s), 8'(s * 7)};
        return v;
    endfunction

    // memory side refuses two cycles out of three
    always @(negedge clk) begin
        cyc++;
        mem_ready <= (cyc % 3) == 0;
    end

    // monitor: pops expected stores and checks the hold rule
    always @(negedge clk) begin
        #2;
        if (rst_n && mem_valid) begin
            chk(!req_ready, "R6 ready low during store", VW'(req_ready), '0);
            if (have_prev)
                chk(mem_addr == prev.addr && mem_data == prev.data && mem_be == prev.be,
                    "R6 held stable", mem_data, prev.data);
            if (mem_ready) begin
                have_prev = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected store", VW'(mem_addr), '0);
                end else begin
                    st_item_t e;
                    e = exp_q.pop_front();
                    popped++;
                    chk(mem_addr == e.addr, "R6 store addr", VW'(mem_addr), VW'(e.addr));
                    chk(mem_data == e.data, "R5 store data", mem_data, e.data);
                    chk(mem_be == e.be, "R5/R4 store byte enables", VW'(mem_be), VW'(e.be));
                end
            end else begin
                prev = '{mem_addr, mem_data, mem_be};
                have_prev = 1'b1;
            end
        end
    end

    task automatic send(input logic to_mem, input logic wide, input logic [2:0] r,
                        input logic [31:0] a, input logic [15:0] m, input logic [VW-1:0] d);
        logic [15:0]   en;
        logic [BW-1:0] be;
        en = sel(wide, m);
        for (int b = 0; b < BW; b++) be[b] = en[b/4];
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_to_mem = to_mem; req_wide = wide;
        req_reg = r; req_addr = a; req_mask = m; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (to_mem) begin
            if (en != 0) begin
                exp_q.push_back('{a, d, be});
                pushed++;
            end else begin
                #1 chk(!mem_valid, "R7 empty store raises nothing", VW'(mem_valid), '0);
            end
        end else begin
            for (int s = 0; s < LANES; s++)
                if (en[s]) model[r][s*SW +: SW] = d[s*SW +: SW];
            #1 chk(!mem_valid, "R9 register write raises no store", VW'(mem_valid), '0);
        end
    endtask

    task automatic read_chk(input logic [2:0] r, input string tag);
        while (!req_ready) @(negedge clk);
        rd_idx = r;
        @(negedge clk);
        chk(rd_data == model[r], tag, rd_data, model[r]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", VW'(req_ready), 1);
        chk(!mem_valid, "R1 no store after reset", VW'(mem_valid), 0);
        read_chk(3'd5, "R1 register zero after reset");

        // R2 narrow full and partial writes, R3 preservation
        send(0, 0, 3'd1, 0, 16'hFFFF, pattern(16'h1111));
        read_chk(3'd1, "R2 full narrow write");
        send(0, 0, 3'd1, 0, 16'h00F0, pattern(16'h2222));
        read_chk(3'd1, "R2/R3 partial narrow write keeps others");
        send(0, 0, 3'd1, 0, 16'h8001, pattern(16'h3333));
        read_chk(3'd1, "R3 edge lanes only");

        // R4 wide mode
        send(0, 0, 3'd2, 0, 16'hFFFF, pattern(16'h4444));
        send(0, 1, 3'd2, 0, 16'hFF05, pattern(16'h5555));
        read_chk(3'd2, "R4 wide pairs, upper bits ignored");
        send(0, 1, 3'd2, 0, 16'hFF00, pattern(16'h6666));
        read_chk(3'd2, "R4 wide upper bits only changes nothing");

        // R7 empty narrow register write
        send(0, 0, 3'd2, 0, 16'h0000, pattern(16'h7777));
        read_chk(3'd2, "R7 empty register write changes nothing");

        // stores: R5, R6, R9
        send(1, 0, 3'd1, 32'h0000_1000, 16'h8001, pattern(16'h8888));
        send(1, 1, 3'd1, 32'h0000_2040, 16'h0081, pattern(16'h9999));
        send(1, 0, 3'd1, 32'h0000_3080, 16'hFFFF, pattern(16'hAAAA));
        send(1, 0, 3'd1, 32'h0000_40C0, 16'h0000, pattern(16'hBBBB));
        send(1, 1, 3'd1, 32'h0000_5100, 16'hFF00, pattern(16'hCCCC));
        send(1, 1, 3'd1, 32'h0000_6140, 16'h00FF, pattern(16'hDDDD));
        read_chk(3'd1, "R9 stores leave register file alone");

        // R8 read in the same cycle as a write to the same entry
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_to_mem = 1'b0; req_wide = 1'b0; req_reg = 3'd1;
        req_mask = 16'hFFFF; req_data = pattern(16'hEEEE); rd_idx = 3'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rd_data == model[1], "R8 same-cycle read returns old value", rd_data, model[1]);
        model[1] = pattern(16'hEEEE);
        read_chk(3'd1, "R8 following read returns new value");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && popped == pushed, "R6 every store retired",
            VW'(popped), VW'(pushed));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule